// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Driver

This block is the digital part of a common-electrode (row) driver for a dot-matrix liquid crystal panel. A chain of eighty single-bit stages carries a scan token along the panel rows, one stage per rising edge of the shift clock. A direction input chooses which end the data enters from. The end port at the far side drives the last stage's bit out, so that further drivers can be chained for taller panels. The near end port is released: its output enable is low and its output is zero.

Each row gets a 2-bit code that selects one of four bias rails. The code depends on whether the row's stage holds a one, on the frame-alternation input and on a display-blank input. The analog switches that turn the code into a voltage sit outside this block. The frame duty (1/64 to 1/256) is set by how many shift clocks the controller issues per frame. It does not depend on the register length, so any bit pattern may be shifted through.

Top module: `lcd_row_driver`

## Requirements
- R1: While `rst_n` is low, every stage is zero at once (no clock is needed). Every row then shows the unselected code for the current `alt_m`, and both end outputs read 0.
- R2: With `shift_left`=0, each rising `clk` loads `end_a_in` into row 0 and moves row k-1 into row k.
- R3: With `shift_left`=1, each rising `clk` loads `end_b_in` into the last row and moves row k+1 into row k.
- R4: With `shift_left`=0, `end_a_oe`=0 and `end_b_oe`=1, and `end_b_out` equals the last row's stage. A one entered at end A therefore appears on `end_b_out` after the NUM_ROWS-th clock.
- R5: With `shift_left`=1, `end_b_oe`=0 and `end_a_oe`=1, and `end_a_out` equals row 0's stage.
- R6: An end port whose enable is 0 drives 0 on its output.
- R7: Row i's code sits in `row_code[2i+1:2i]`, with 00=V1, 01=V2, 10=V5 and 11=VEE. A row whose stage is 1 shows VEE when `alt_m`=0 and V1 when `alt_m`=1. A row whose stage is 0 shows V2 when `alt_m`=0 and V5 when `alt_m`=1.
- R8: While `disp_off`=1, every row shows the unselected code for the current `alt_m`. Shifting goes on unchanged, so the stored pattern shows again once `disp_off` returns to 0.
- R9: Several stages may hold ones at the same time. Each of them shifts and is encoded on its own, independent of the other stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| shift_left | input | 1 | 0: enter at end A, move toward the last row; 1: enter at end B, move toward row 0 |
| alt_m | input | 1 | Frame alternation phase |
| disp_off | input | 1 | 1 forces all rows to the unselected level |
| end_a_in | input | 1 | Data in at the row-0 end |
| end_a_out | output | 1 | Cascade data out at the row-0 end |
| end_a_oe | output | 1 | Output enable of the row-0 end |
| end_b_in | input | 1 | Data in at the last-row end |
| end_b_out | output | 1 | Cascade data out at the last-row end |
| end_b_oe | output | 1 | Output enable of the last-row end |
| row_code | output | 2*NUM_ROWS | Level-select code per row, two bits each |

## Verification
A single token is walked the full length in each direction while `alt_m` toggles. This separates the entry point, the stage ordering and the moment it reaches the cascade output, and it checks both polarities of the selected and unselected codes. A multi-bit pattern (1,0,1,1) is then shifted forward, which catches stages that are tied to their neighbours or swapped. A blanking window placed in the middle of a shift checks that the codes are forced while the register keeps moving. A reset pulse in the middle of a run, with no clock, confirms that the clear is asynchronous.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;

  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_V2  = 2'b01,
    LVL_V5  = 2'b10,
    LVL_VEE = 2'b11
  } lvl_t;

  // Rail choice for one row: a selected row swings to the outer rail
  // opposite the alternation phase, an idle row stays on the inner rails.
  function automatic lvl_t pick_level(input logic sel, input logic m,
                                      input logic off);
    logic active;
    active = sel & ~off;
    if (active) return m ? LVL_V1 : LVL_VEE;
    else        return m ? LVL_V5 : LVL_V2;
  endfunction

endpackage

// File: rtl/lcd_row_shift.sv
module lcd_row_shift #(
  parameter int NUM_ROWS = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_left,
  input  logic                head_in,
  input  logic                tail_in,
  output logic [NUM_ROWS-1:0] stages
);

  logic [NUM_ROWS-1:0] nxt;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_first
      assign from_low = head_in;
    end else begin : g_mid_low
      assign from_low = stages[i-1];
    end
    if (i == NUM_ROWS - 1) begin : g_last
      assign from_high = tail_in;
    end else begin : g_mid_high
      assign from_high = stages[i+1];
    end
    assign nxt[i] = shift_left ? from_high : from_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= nxt;
  end

endmodule

// File: rtl/lcd_row_endport.sv
module lcd_row_endport (
  input  logic shift_left,
  input  logic first_stage,
  input  logic last_stage,
  output logic a_out,
  output logic a_oe,
  output logic b_out,
  output logic b_oe
);

  assign a_oe  = shift_left;
  assign b_oe  = ~shift_left;
  assign a_out = shift_left  & first_stage;
  assign b_out = ~shift_left & last_stage;

endmodule

// File: rtl/lcd_row_level_enc.sv
module lcd_row_level_enc
  import lcd_row_pkg::*;
#(
  parameter int NUM_ROWS = 80
) (
  input  logic [NUM_ROWS-1:0]   stages,
  input  logic                  alt_m,
  input  logic                  disp_off,
  output logic [2*NUM_ROWS-1:0] codes
);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    lvl_t lvl;
    assign lvl            = pick_level(stages[i], alt_m, disp_off);
    assign codes[2*i +: 2] = lvl;
  end

endmodule

// File: rtl/lcd_row_driver.sv
module lcd_row_driver #(
  parameter int NUM_ROWS = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_left,
  input  logic                  alt_m,
  input  logic                  disp_off,
  input  logic                  end_a_in,
  output logic                  end_a_out,
  output logic                  end_a_oe,
  input  logic                  end_b_in,
  output logic                  end_b_out,
  output logic                  end_b_oe,
  output logic [2*NUM_ROWS-1:0] row_code
);

  logic [NUM_ROWS-1:0] stages;

  lcd_row_shift #(.NUM_ROWS(NUM_ROWS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_left (shift_left),
    .head_in    (end_a_in),
    .tail_in    (end_b_in),
    .stages     (stages)
  );

  lcd_row_endport u_ports (
    .shift_left  (shift_left),
    .first_stage (stages[0]),
    .last_stage  (stages[NUM_ROWS-1]),
    .a_out       (end_a_out),
    .a_oe        (end_a_oe),
    .b_out       (end_b_out),
    .b_oe        (end_b_oe)
  );

  lcd_row_level_enc #(.NUM_ROWS(NUM_ROWS)) u_enc (
    .stages   (stages),
    .alt_m    (alt_m),
    .disp_off (disp_off),
    .codes    (row_code)
  );

endmodule

// File: rtl/lcd_row_driver_chk.sv
module lcd_row_driver_chk #(
  parameter int NUM_ROWS = 80
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shift_left,
  input logic                  alt_m,
  input logic                  disp_off,
  input logic                  end_a_in,
  input logic                  end_b_in,
  input logic                  end_a_oe,
  input logic                  end_a_out,
  input logic                  end_b_oe,
  input logic                  end_b_out,
  input logic [NUM_ROWS-1:0]   stages,
  input logic [2*NUM_ROWS-1:0] row_code
);

  function automatic logic any_selected(input logic [2*NUM_ROWS-1:0] c,
                                        input logic m);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_ROWS; i++)
      if (c[2*i +: 2] == (m ? 2'b00 : 2'b11)) hit = 1'b1;
    return hit;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> stages == '0);

  a_r2_fwd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_left |=> stages[0] == $past(end_a_in));

  a_r3_rev_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_left |=> stages[NUM_ROWS-1] == $past(end_b_in));

  a_r4_fwd_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_left |-> (end_b_oe && !end_a_oe && end_b_out == stages[NUM_ROWS-1]));

  a_r5_rev_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    shift_left |-> (end_a_oe && !end_b_oe && end_a_out == stages[0]));

  a_r6_idle_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    !end_a_oe |-> !end_a_out);

  a_r6_idle_b_low: assert property (@(posedge clk) disable iff (!rst_n)
    !end_b_oe |-> !end_b_out);

  a_r7_row0_sel_m0: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_off && stages[0] && !alt_m) |-> row_code[1:0] == 2'b11);

  a_r8_blank_forced: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> !any_selected(row_code, alt_m));

endmodule

bind lcd_row_driver lcd_row_driver_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_left (shift_left),
  .alt_m      (alt_m),
  .disp_off   (disp_off),
  .end_a_in   (end_a_in),
  .end_b_in   (end_b_in),
  .end_a_oe   (end_a_oe),
  .end_a_out  (end_a_out),
  .end_b_oe   (end_b_oe),
  .end_b_out  (end_b_out),
  .stages     (stages),
  .row_code   (row_code)
);

// File: tb/lcd_row_driver_bench.sv
module lcd_row_driver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_left = 1'b0, alt_m = 1'b0, disp_off = 1'b0;
  logic end_a_in = 1'b0, end_b_in = 1'b0;
  logic end_a_out, end_a_oe, end_b_out, end_b_oe;
  logic [2*N-1:0] row_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2*N-1:0] rows;
    logic [3:0]     ports;   // {a_oe, a_out, b_oe, b_out}
    string          tag;
  } exp_t;

  exp_t sb[$];
  logic model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_row_driver #(.NUM_ROWS(N)) u_lcd_row_driver (
    .clk(clk), .rst_n(rst_n), .shift_left(shift_left), .alt_m(alt_m),
    .disp_off(disp_off), .end_a_in(end_a_in), .end_a_out(end_a_out),
    .end_a_oe(end_a_oe), .end_b_in(end_b_in), .end_b_out(end_b_out),
    .end_b_oe(end_b_oe), .row_code(row_code)
  );

  // Rail table indexed by {blank-or-idle, m}: lit rows m0->VEE, m1->V1;
  // dark rows m0->V2, m1->V5.
  function automatic logic [1:0] ref_code(input logic bit_v, input logic m,
                                          input logic off);
    logic [1:0] lit [2];
    logic [1:0] dark [2];
    lit[0] = 2'b11; lit[1] = 2'b00;
    dark[0] = 2'b01; dark[1] = 2'b10;
    if (off || !bit_v) return dark[m];
    return lit[m];
  endfunction

  function automatic logic [2*N-1:0] ref_rows(input logic m, input logic off);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = ref_code(model[i], m, off);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one shift with inputs held for a whole cycle, push the
  // expected post-edge view.
  task automatic step(input logic dir, input logic ain, input logic bin,
                      input logic m, input logic off, input string tag);
    exp_t e;
    @(negedge clk);
    shift_left = dir; end_a_in = ain; end_b_in = bin;
    alt_m = m; disp_off = off;
    if (!dir) begin
      for (int i = N-1; i > 0; i--) model[i] = model[i-1];
      model[0] = ain;
    end else begin
      for (int i = 0; i < N-1; i++) model[i] = model[i+1];
      model[N-1] = bin;
    end
    e.rows  = ref_rows(m, off);
    e.ports = dir ? {1'b1, model[0], 1'b0, 1'b0}
                  : {1'b0, 1'b0, 1'b1, model[N-1]};
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: a quarter period after each edge, compare with the queue head.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(row_code === e.rows, {e.tag, " rows"}, row_code, e.rows);
        check({end_a_oe, end_a_out, end_b_oe, end_b_out} === e.ports,
              {e.tag, " ends"},
              {{(2*N-4){1'b0}}, end_a_oe, end_a_out, end_b_oe, end_b_out},
              {{(2*N-4){1'b0}}, e.ports});
      end
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    #(CLK_PERIOD*2 + 1);
    // R1: state during reset, no clock dependency
    check(row_code === ref_rows(1'b0, 1'b0), "R1 reset rows", row_code,
          ref_rows(1'b0, 1'b0));
    check({end_a_out, end_b_out} === 2'b00, "R1 reset ends",
          {{(2*N-2){1'b0}}, end_a_out, end_b_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R4/R7: single token forward, alt_m toggling every 3 steps
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R7 fwd token entry");
    for (int k = 1; k < N + 2; k++)
      step(1'b0, 1'b0, 1'b0, logic'((k / 3) % 2), 1'b0,
           (k == N-1) ? "R4 fwd token at cascade" : "R2 R4 R7 fwd walk");
    drain();

    // R3/R5/R6: single token reverse
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3 R7 rev token entry");
    for (int k = 1; k < N + 2; k++)
      step(1'b1, 1'b1, 1'b0, logic'((k / 5) % 2), 1'b0,
           (k == N-1) ? "R5 R6 rev token at cascade" : "R3 R5 R6 rev walk");
    drain();

    // R9: pattern 1,0,1,1 forward, then R8 blanking in mid-shift
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 pattern");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 pattern");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 pattern");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 pattern");
    for (int k = 0; k < 6; k++)
      step(1'b0, 1'b0, 1'b0, logic'(k % 2), 1'b1, "R8 blank forced");
    for (int k = 0; k < 6; k++)
      step(1'b0, 1'b0, 1'b0, logic'(k % 2), 1'b0, "R8 R9 pattern kept");
    drain();

    // R1: asynchronous clear mid-run, between clock edges
    #(CLK_PERIOD/8);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    check(row_code === ref_rows(alt_m, 1'b0), "R1 async clear rows", row_code,
          ref_rows(alt_m, 1'b0));
    check({end_a_out, end_b_out} === 2'b00, "R1 async clear ends",
          {{(2*N-2){1'b0}}, end_a_out, end_b_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 after clear");
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule